// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block moves the data of one storage command between a device-side sector buffer and host memory. It does not take one contiguous buffer. It walks a table of region descriptors in memory. When the device has reached its DMA-ready point and the host sets the run bit, the engine fetches the first descriptor from the table pointer and moves that region. It then fetches the next descriptor, and repeats until the region marked as the last one is done.

Every region is cut into bursts, and no burst crosses a page boundary. Descriptor fetches and data bursts share one request/response memory port. That port has a busy line. When a request is due and the port is busy, the engine stays quiet for a fixed backoff interval and then tries again. The direction of the data bursts is the opposite of the disk direction: a disk read command writes memory, and a disk write command reads memory. The engine keeps a remaining-byte count for the command. At the end of the command it checks that count against the last-region flag. It then reports success or error to the device state machine and to its bus-master status flags. It also keeps per-direction traffic counters.

Top module: `prd_sg_dma`

## Requirements
- R1: On start, the first descriptor fetch (mem_desc=1, mem_we=0, mem_len=8) is sent to tbl_ptr with bits 1:0 forced to zero.
- R2: Each later descriptor fetch of the same command is sent to the previous fetch address plus 8.
- R3: A 64-bit descriptor carries the region base in bits 31:0, the region byte count in bits 47:32 and the last-region flag in bit 63. A count of zero means 65536 bytes.
- R4: The bursts of a region cover it in ascending, back-to-back order. Each burst length is the smaller of the bytes left in the region and the bytes up to the next PAGE_BYTES boundary, so no burst crosses a page.
- R5: While mem_busy is high, a due request is not issued. The engine waits BACKOFF cycles and presents the request again BACKOFF+1 cycles after the blocked attempt.
- R6: With to_mem=1 (disk read command), data bursts have mem_we=1. With to_mem=0 (disk write command), they have mem_we=0.
- R7: A command starts only while go and dma_ready are both high. bm_active stays low until then.
- R8: A command ends well when the last-flagged region finishes and the command byte count is used up exactly. done_o pulses for one cycle, err_o stays low, and bm_irq is set unless irq_mask is high.
- R9: A command ends in error when the last-flagged region leaves bytes of the command unmoved, or when a region without the last flag uses up the command count. done_o pulses with err_o, bm_err is set, and no further descriptor is fetched.
- R10: Dropping go while the engine is active ends the command at once. done_o and err_o pulse, and no request is issued afterwards.
- R11: For each direction, counters hold the bytes moved, the bursts acknowledged and the bursts that were a full page.
- R12: A one-cycle stat_clr clears bm_irq and bm_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_ptr | input | 32 | Descriptor table pointer; bits 1:0 ignored |
| go | input | 1 | Host run bit; low while active aborts |
| dma_ready | input | 1 | Device has reached its DMA-ready point |
| to_mem | input | 1 | 1: disk read command (memory writes) |
| cmd_bytes | input | CMD_W | Byte length of the command |
| irq_mask | input | 1 | Suppresses setting bm_irq |
| stat_clr | input | 1 | Clears bm_irq and bm_err |
| mem_req | output | 1 | Memory request strobe |
| mem_desc | output | 1 | Request is a descriptor fetch |
| mem_we | output | 1 | Request writes memory |
| mem_addr | output | 32 | Request byte address |
| mem_len | output | LEN_W | Request byte length |
| mem_busy | input | 1 | Memory port cannot take a request |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rdata | input | 64 | Descriptor returned by a fetch |
| done_o | output | 1 | Command finished (one-cycle pulse) |
| err_o | output | 1 | Finished command ended in error |
| bm_active | output | 1 | Engine owns a command |
| bm_irq | output | 1 | Bus-master interrupt status |
| bm_err | output | 1 | Bus-master error status |
| mrd_bytes | output | STAT_W | Bytes read from memory |
| mrd_txs | output | STAT_W | Memory-read bursts |
| mrd_pages | output | STAT_W | Full-page memory-read bursts |
| mwr_bytes | output | STAT_W | Bytes written to memory |
| mwr_txs | output | STAT_W | Memory-write bursts |
| mwr_pages | output | STAT_W | Full-page memory-write bursts |

## Verification
The bench builds the engine with PAGE_BYTES=256 and BACKOFF=3. The small page makes a 512-byte region at an odd offset split into partial and full-page bursts. It also makes a zero-count descriptor (65536 bytes) become 256 separate bursts that the bench can enumerate. The short backoff lets the bench predict the exact retry cycle after a blocked attempt. The stop, short-table and long-table cases each finish within a few dozen cycles.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

   localparam int DESC_BYTES = 8;
   localparam int RGN_W      = 17;

   typedef enum logic [2:0] {
      S_IDLE, S_FREQ, S_FWAIT, S_XREQ, S_XWAIT, S_BOFF, S_HOLD
   } sgd_state_e;

   typedef struct packed {
      logic        last;
      logic [14:0] rsvd;
      logic [15:0] cnt;
      logic [31:0] base;
   } sgd_desc_t;

   function automatic logic [RGN_W-1:0] region_bytes(input logic [15:0] c);
      return (c == 16'd0) ? RGN_W'(65536) : {1'b0, c};
   endfunction

endpackage

// File: rtl/sgd_split.sv
module sgd_split #(
   parameter int PAGE_BYTES = 4096,
   parameter int RGN_W      = 17,
   localparam int PG_W      = $clog2(PAGE_BYTES),
   localparam int LEN_W     = PG_W + 1
) (
   input  logic [PG_W-1:0]  offs_i,
   input  logic [RGN_W-1:0] left_i,
   output logic [LEN_W-1:0] len_o,
   output logic             full_o
);
   logic [LEN_W-1:0] room;
   logic             fits;

   assign room   = LEN_W'(PAGE_BYTES) - {1'b0, offs_i};
   assign fits   = left_i < RGN_W'(room);
   assign len_o  = fits ? left_i[LEN_W-1:0] : room;
   assign full_o = (len_o == LEN_W'(PAGE_BYTES));
endmodule

// File: rtl/sgd_backoff.sv
module sgd_backoff #(
   parameter int BACKOFF = 16,
   localparam int BW     = $clog2(BACKOFF + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);
   logic [BW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (start_i)        cnt <= BW'(BACKOFF - 1);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign done_o = (cnt == '0);

   AST_BOFF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt == BW'(BACKOFF - 1)));  // R5
endmodule

// File: rtl/sgd_stats.sv
module sgd_stats #(
   parameter int STAT_W = 32,
   parameter int LEN_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              full_i,
   output logic [STAT_W-1:0] bytes_o,
   output logic [STAT_W-1:0] txs_o,
   output logic [STAT_W-1:0] pages_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bytes_o <= '0;
         txs_o   <= '0;
         pages_o <= '0;
      end else if (hit_i) begin
         bytes_o <= bytes_o + STAT_W'(len_i);
         txs_o   <= txs_o + 1'b1;
         if (full_i) pages_o <= pages_o + 1'b1;
      end
   end

   AST_TXS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> (txs_o == $past(txs_o) + 1'b1));  // R11
endmodule

// File: rtl/prd_sg_dma.sv
module prd_sg_dma
   import sgd_pkg::*;
#(
   parameter int PAGE_BYTES = 4096,
   parameter int BACKOFF    = 16,
   parameter int CMD_W      = 18,
   parameter int STAT_W     = 32,
   localparam int PG_W      = $clog2(PAGE_BYTES),
   localparam int LEN_W     = PG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       tbl_ptr,
   input  logic              go,
   input  logic              dma_ready,
   input  logic              to_mem,
   input  logic [CMD_W-1:0]  cmd_bytes,
   input  logic              irq_mask,
   input  logic              stat_clr,
   output logic              mem_req,
   output logic              mem_desc,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [LEN_W-1:0]  mem_len,
   input  logic              mem_busy,
   input  logic              mem_rsp_valid,
   input  logic [63:0]       mem_rdata,
   output logic              done_o,
   output logic              err_o,
   output logic              bm_active,
   output logic              bm_irq,
   output logic              bm_err,
   output logic [STAT_W-1:0] mrd_bytes,
   output logic [STAT_W-1:0] mrd_txs,
   output logic [STAT_W-1:0] mrd_pages,
   output logic [STAT_W-1:0] mwr_bytes,
   output logic [STAT_W-1:0] mwr_txs,
   output logic [STAT_W-1:0] mwr_pages
);

   initial begin
      assert ((1 << PG_W) == PAGE_BYTES && PAGE_BYTES >= 16 && PAGE_BYTES <= 32768)
         else $error("PAGE_BYTES must be a power of two in 16..32768");
      assert (BACKOFF >= 1) else $error("BACKOFF must be at least 1");
      assert (CMD_W > LEN_W && CMD_W <= 32) else $error("CMD_W out of range");
   end

   sgd_state_e        state, state_n;
   logic [31:0]       ptr, cur_addr;
   logic [RGN_W-1:0]  rgn_left, left_nxt;
   logic              rgn_last, dir_q, ret_fetch, under, under_nxt, short_b;
   logic [CMD_W-1:0]  rem, rem_nxt;
   logic [LEN_W-1:0]  len_q, split_len;
   logic              split_full, full_q;
   logic              rsp_x, rsp_f, fin, fin_err, bo_done, bo_start;
   sgd_desc_t         rsp_desc;
   logic              unused_bits;

   assign rsp_desc    = sgd_desc_t'(mem_rdata);
   assign unused_bits = ^{rsp_desc.rsvd, tbl_ptr[1:0]};
   assign bm_active   = (state != S_IDLE) && (state != S_HOLD);
   assign rsp_f       = (state == S_FWAIT) && mem_rsp_valid;
   assign rsp_x       = (state == S_XWAIT) && mem_rsp_valid;

   sgd_split #(.PAGE_BYTES(PAGE_BYTES), .RGN_W(RGN_W)) u_split (
      .offs_i (cur_addr[PG_W-1:0]),
      .left_i (rgn_left),
      .len_o  (split_len),
      .full_o (split_full)
   );

   assign bo_start = (state_n == S_BOFF) && (state != S_BOFF);

   sgd_backoff #(.BACKOFF(BACKOFF)) u_backoff (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (bo_start),
      .done_o  (bo_done)
   );

   // memory port
   assign mem_req  = go && !mem_busy && ((state == S_FREQ) || (state == S_XREQ));
   assign mem_desc = (state == S_FREQ);
   assign mem_we   = (state == S_XREQ) && dir_q;
   assign mem_addr = mem_desc ? ptr : cur_addr;
   assign mem_len  = mem_desc ? LEN_W'(DESC_BYTES) : split_len;

   // byte accounting on a burst acknowledge
   assign short_b   = CMD_W'(len_q) > rem;
   assign rem_nxt   = short_b ? '0 : rem - CMD_W'(len_q);
   assign under_nxt = under | short_b;
   assign left_nxt  = rgn_left - RGN_W'(len_q);

   always_comb begin
      fin     = 1'b0;
      fin_err = 1'b0;
      if (bm_active && !go) begin
         fin     = 1'b1;
         fin_err = 1'b1;
      end else if (rsp_x && left_nxt == '0) begin
         if (rgn_last) begin
            fin     = 1'b1;
            fin_err = under_nxt || (rem_nxt != '0);
         end else if (under_nxt || rem_nxt == '0) begin
            fin     = 1'b1;
            fin_err = 1'b1;
         end
      end
   end

   always_comb begin
      state_n = state;
      unique case (state)
         S_IDLE:  if (go && dma_ready) state_n = S_FREQ;
         S_FREQ:  state_n = mem_busy ? S_BOFF : S_FWAIT;
         S_FWAIT: if (mem_rsp_valid) state_n = S_XREQ;
         S_XREQ:  state_n = mem_busy ? S_BOFF : S_XWAIT;
         S_XWAIT: if (mem_rsp_valid) state_n = (left_nxt == '0) ? S_FREQ : S_XREQ;
         S_BOFF:  if (bo_done) state_n = ret_fetch ? S_FREQ : S_XREQ;
         S_HOLD:  if (!go) state_n = S_IDLE;
         default: state_n = S_IDLE;
      endcase
      if (fin) state_n = S_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         ptr       <= '0;
         cur_addr  <= '0;
         rgn_left  <= '0;
         rgn_last  <= 1'b0;
         rem       <= '0;
         under     <= 1'b0;
         dir_q     <= 1'b0;
         ret_fetch <= 1'b0;
         len_q     <= '0;
         full_q    <= 1'b0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
         bm_irq    <= 1'b0;
         bm_err    <= 1'b0;
      end else begin
         state  <= state_n;
         done_o <= fin;
         err_o  <= fin && fin_err;
         bm_irq <= (bm_irq && !stat_clr) || (fin && !irq_mask);
         bm_err <= (bm_err && !stat_clr) || (fin && fin_err);
         if (state == S_IDLE && go && dma_ready) begin
            ptr   <= {tbl_ptr[31:2], 2'b00};
            rem   <= cmd_bytes;
            under <= 1'b0;
            dir_q <= to_mem;
         end
         if ((state == S_FREQ || state == S_XREQ) && mem_busy)
            ret_fetch <= (state == S_FREQ);
         if (rsp_f) begin
            cur_addr <= rsp_desc.base;
            rgn_left <= region_bytes(rsp_desc.cnt);
            rgn_last <= rsp_desc.last;
            ptr      <= ptr + 32'(DESC_BYTES);
         end
         if (state == S_XREQ && mem_req) begin
            len_q  <= split_len;
            full_q <= split_full;
         end
         if (rsp_x) begin
            cur_addr <= cur_addr + 32'(len_q);
            rgn_left <= left_nxt;
            rem      <= rem_nxt;
            under    <= under_nxt;
         end
      end
   end

   // per-direction traffic counters
   for (genvar d = 0; d < 2; d++) begin : g_dir
      logic [STAT_W-1:0] s_bytes, s_txs, s_pages;
      sgd_stats #(.STAT_W(STAT_W), .LEN_W(LEN_W)) u_stats (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit_i   (rsp_x && (dir_q == d[0])),
         .len_i   (len_q),
         .full_i  (full_q),
         .bytes_o (s_bytes),
         .txs_o   (s_txs),
         .pages_o (s_pages)
      );
   end
   assign mrd_bytes = g_dir[0].s_bytes;
   assign mrd_txs   = g_dir[0].s_txs;
   assign mrd_pages = g_dir[0].s_pages;
   assign mwr_bytes = g_dir[1].s_bytes;
   assign mwr_txs   = g_dir[1].s_txs;
   assign mwr_pages = g_dir[1].s_pages;

   AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_desc) |-> (mem_addr[1:0] == 2'b00));  // R1
   AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_desc) |-> (({1'b0, mem_addr[PG_W-1:0]} + mem_len) <= LEN_W'(PAGE_BYTES)));  // R4
   AST_BUSY_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_busy && go && (state == S_FREQ || state == S_XREQ)) |=> !mem_req);  // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);  // R8
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);  // R9
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bm_active && !go) |=> !bm_active);  // R10
   AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !done_o && !fin) |=> !bm_irq);  // R12

endmodule

// File: tb/prd_sg_dma_bench.sv
module prd_sg_dma_bench;
   localparam int PAGE = 256;
   localparam int BOFF = 3;
   localparam int LW   = 9;
   localparam logic [31:0] TBL = 32'h0000_8000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [31:0] tbl_ptr = '0;
   logic go = 0, dma_ready = 0, to_mem = 0, irq_mask = 0, stat_clr = 0;
   logic [17:0] cmd_bytes = '0;
   logic mem_req, mem_desc, mem_we, mem_busy = 0, mem_rsp_valid;
   logic [31:0] mem_addr;
   logic [LW-1:0] mem_len;
   logic [63:0] mem_rdata;
   logic done_o, err_o, bm_active, bm_irq, bm_err;
   logic [31:0] mrd_bytes, mrd_txs, mrd_pages, mwr_bytes, mwr_txs, mwr_pages;

   always #5 clk = ~clk;

   prd_sg_dma #(.PAGE_BYTES(PAGE), .BACKOFF(BOFF), .CMD_W(18), .STAT_W(32)) u_prd_sg_dma (
      .clk(clk), .rst_n(rst_n), .tbl_ptr(tbl_ptr), .go(go), .dma_ready(dma_ready),
      .to_mem(to_mem), .cmd_bytes(cmd_bytes), .irq_mask(irq_mask), .stat_clr(stat_clr),
      .mem_req(mem_req), .mem_desc(mem_desc), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_len(mem_len), .mem_busy(mem_busy), .mem_rsp_valid(mem_rsp_valid),
      .mem_rdata(mem_rdata), .done_o(done_o), .err_o(err_o), .bm_active(bm_active),
      .bm_irq(bm_irq), .bm_err(bm_err), .mrd_bytes(mrd_bytes), .mrd_txs(mrd_txs),
      .mrd_pages(mrd_pages), .mwr_bytes(mwr_bytes), .mwr_txs(mwr_txs), .mwr_pages(mwr_pages));

   // memory model and request log
   logic [63:0] dtab [8];
   logic        log_clr = 0;
   int          cyc = 0, nf = 0, nb = 0, first_cyc = -1;
   logic [31:0] fa [16];
   logic [31:0] ba [512];
   int          bl [512];
   logic        bw [512];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rsp_valid <= mem_req;
      mem_rdata <= (mem_req && mem_desc) ? dtab[3'((mem_addr - TBL) >> 3)] : 64'd0;
      if (log_clr) begin
         nf <= 0; nb <= 0; first_cyc <= -1;
      end else if (mem_req) begin
         if (first_cyc < 0) first_cyc <= cyc;
         if (mem_desc) begin
            if (nf < 16) fa[nf] <= mem_addr;
            nf <= nf + 1;
         end else begin
            if (nb < 512) begin ba[nb] <= mem_addr; bl[nb] <= int'(mem_len); bw[nb] <= mem_we; end
            nb <= nb + 1;
         end
      end
   end

   int checks = 0, fails = 0;
   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected bursts, computed from R3/R4
   int          ne = 0;
   logic [31:0] ea [512];
   int          el [512];
   longint      es [2][3];

   function automatic logic [63:0] mkd(input logic last, input int cnt, input logic [31:0] base);
      return {last, 15'd0, 16'(cnt), base};
   endfunction

   task automatic add_region(input logic [31:0] base, input int cnt);
      int left = (cnt == 0) ? 65536 : cnt;
      logic [31:0] a = base;
      while (left > 0) begin
         int room = PAGE - int'(a % PAGE);
         int l = (left < room) ? left : room;
         ea[ne] = a; el[ne] = l; ne++;
         a += 32'(l); left -= l;
      end
   endtask

   task automatic cmp_bursts(input string req, input logic dir);
      chk(nb == ne, req, nb, ne);
      for (int i = 0; i < ne && i < nb; i++) begin
         chk(ba[i] == ea[i] && bl[i] == el[i], req, ba[i] + bl[i], ea[i] + el[i]);
         chk(bw[i] == dir, "R6", bw[i], dir);
         es[dir][0] += el[i]; es[dir][1] += 1;
         if (el[i] == PAGE) es[dir][2] += 1;
      end
   endtask

   int c0 = 0;
   logic got_done, got_err;
   task automatic run_cmd(input int cmd, input logic dir, input int busy_hold, input int stop_at);
      @(negedge clk) log_clr = 1;
      @(negedge clk) log_clr = 0;
      tbl_ptr = TBL | 32'd3; cmd_bytes = 18'(cmd); to_mem = dir;
      dma_ready = 1; go = 1; c0 = cyc;
      got_done = 0; got_err = 0;
      for (int i = 0; i < 20000 && !got_done; i++) begin
         @(negedge clk);
         if (i == busy_hold) mem_busy = 0;
         if (done_o) begin got_done = 1; got_err = err_o; end
         else if (i == stop_at) go = 0;
      end
      go = 0; dma_ready = 0; mem_busy = 0;
      @(negedge clk); @(negedge clk);
   endtask

   // vector table: {to_mem, base, count}; one last-flagged region each
   localparam logic [48:0] VEC [4] = '{
      {1'b0, 32'h0000_2000, 16'd512},
      {1'b1, 32'h0000_2080, 16'd512},
      {1'b0, 32'h0000_30F0, 16'd1024},
      {1'b1, 32'h0000_4000, 16'd1536}
   };

   initial begin
      for (int d = 0; d < 2; d++) for (int k = 0; k < 3; k++) es[d][k] = 0;
      for (int i = 0; i < 8; i++) dtab[i] = '0;
      repeat (3) @(negedge clk);
      chk(!bm_active && !bm_irq && !bm_err && !done_o && !mem_req, "reset", bm_active, 0);
      chk(mrd_txs == 0 && mwr_txs == 0, "reset R11", mrd_txs + mwr_txs, 0);
      rst_n = 1;

      for (int v = 0; v < 4; v++) begin
         dtab[0] = mkd(1'b1, int'(VEC[v][15:0]), VEC[v][47:16]);
         ne = 0; add_region(VEC[v][47:16], int'(VEC[v][15:0]));
         run_cmd(int'(VEC[v][15:0]), VEC[v][48], -1, -1);
         chk(got_done && !got_err, "R8", got_err, 0);
         chk(nf == 1 && fa[0] == TBL, "R1", fa[0], TBL);
         cmp_bursts("R4", VEC[v][48]);
         chk(bm_irq == 1, "R8 irq", bm_irq, 1);
         @(negedge clk) stat_clr = 1;
         @(negedge clk) stat_clr = 0;
         chk(bm_irq == 0, "R12", bm_irq, 0);
      end

      // R2 multi-descriptor table
      dtab[0] = mkd(1'b0, 512, 32'h5010);
      dtab[1] = mkd(1'b0, 1024, 32'h6000);
      dtab[2] = mkd(1'b1, 512, 32'h70F8);
      ne = 0; add_region(32'h5010, 512); add_region(32'h6000, 1024); add_region(32'h70F8, 512);
      run_cmd(2048, 1'b1, -1, -1);
      chk(got_done && !got_err, "R2 ok", got_err, 0);
      chk(nf == 3, "R2 fetches", nf, 3);
      chk(fa[1] == TBL + 8 && fa[2] == TBL + 16, "R2", fa[2], TBL + 16);
      cmp_bursts("R4 multi", 1'b1);

      // R3 zero count means 65536 bytes
      dtab[0] = mkd(1'b1, 0, 32'h0001_0000);
      ne = 0; add_region(32'h0001_0000, 0);
      run_cmd(65536, 1'b0, -1, -1);
      chk(got_done && !got_err, "R3", got_err, 0);
      cmp_bursts("R3", 1'b0);

      // R9 last region leaves bytes unmoved
      dtab[0] = mkd(1'b1, 512, 32'h9000);
      ne = 0; add_region(32'h9000, 512);
      run_cmd(1024, 1'b0, -1, -1);
      chk(got_done && got_err && bm_err, "R9 short table", got_err, 1);
      cmp_bursts("R9", 1'b0);
      @(negedge clk) stat_clr = 1;
      @(negedge clk) stat_clr = 0;
      chk(!bm_err, "R12 err", bm_err, 0);

      // R9 table runs past the command without last flag
      dtab[0] = mkd(1'b0, 512, 32'hA000);
      dtab[1] = mkd(1'b1, 512, 32'hB000);
      ne = 0; add_region(32'hA000, 512);
      run_cmd(512, 1'b1, -1, -1);
      chk(got_done && got_err, "R9 long table", got_err, 1);
      chk(nf == 1, "R9 no fetch", nf, 1);
      cmp_bursts("R9", 1'b1);

      // R5 busy backoff
      dtab[0] = mkd(1'b1, 512, 32'hC000);
      ne = 0; add_region(32'hC000, 512);
      mem_busy = 1;
      run_cmd(512, 1'b0, 1, -1);
      chk(first_cyc == c0 + BOFF + 2, "R5", first_cyc, c0 + BOFF + 2);
      chk(got_done && !got_err, "R5 done", got_err, 0);
      cmp_bursts("R5", 1'b0);

      // R10 stop while active
      mem_busy = 1;
      run_cmd(512, 1'b0, 100000, 10);
      chk(got_done && got_err, "R10", got_err, 1);
      chk(nf == 0 && nb == 0, "R10 quiet", nf + nb, 0);
      chk(!bm_active, "R10 idle", bm_active, 0);

      // R8 masked interrupt
      @(negedge clk) stat_clr = 1;
      @(negedge clk) stat_clr = 0;
      irq_mask = 1;
      dtab[0] = mkd(1'b1, 512, 32'hD000);
      ne = 0; add_region(32'hD000, 512);
      run_cmd(512, 1'b1, -1, -1);
      chk(got_done && bm_irq == 0, "R8 mask", bm_irq, 0);
      cmp_bursts("R8", 1'b1);
      irq_mask = 0;

      // R7 no start without dma_ready
      @(negedge clk) log_clr = 1;
      @(negedge clk) log_clr = 0;
      go = 1; dma_ready = 0;
      repeat (8) @(negedge clk);
      chk(!bm_active && nf == 0, "R7", nf, 0);
      go = 0;
      @(negedge clk);

      // R11 counters
      chk(mrd_bytes == es[0][0] && mrd_txs == es[0][1] && mrd_pages == es[0][2],
          "R11 rd", mrd_bytes, es[0][0]);
      chk(mwr_bytes == es[1][0] && mwr_txs == es[1][1] && mwr_pages == es[1][2],
          "R11 wr", mwr_bytes, es[1][0]);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #(10 * 150000);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule